// File: doc/BRIEF.md
# Accumulator-Slice XOR Execution Unit

This unit carries out the exclusive-OR operation of a fixed-point signal-processing datapath. It holds four 24-bit operand registers and two 56-bit accumulators. A 56-bit accumulator is made of an 8-bit guard byte (bits 55..48), a 24-bit middle slice (bits 47..24) and a 24-bit low part (bits 23..0). On an issue strobe, the unit XORs the selected operand register into the middle slice of the selected accumulator. The guard byte and the low part are left as they were. It then updates the negative, zero, overflow and limit condition-code bits from the new slice.

Control is a three-state machine:
- ST_IDLE goes to ST_EXEC when an issue strobe arrives.
- ST_EXEC goes to ST_COMMIT on the next clock.
- ST_COMMIT goes back to ST_IDLE on the next clock.

`done` is high throughout ST_COMMIT. The accumulator write and the flag writes take effect together on the clock edge that ends ST_COMMIT. Operand selects and the limiting-event input are captured on the issue edge.

A load port presets the operand registers, the accumulators and the condition-code register while the unit is idle. A flag-clear input drops the sticky limit flag.

Top module: `acc_xor_unit`

## Requirements
- R1: On completion, bits 47..24 of the chosen accumulator hold the old slice XOR the chosen operand. The other accumulator is unchanged.
- R2: Bits 55..48 and 23..0 of both accumulators keep their values through an operation.
- R3: Select encodings:
  - `src_sel`: 0 = X0, 1 = X1, 2 = Y0, 3 = Y1.
  - `dst_sel`: 0 = A, 1 = B.
  - `ld_sel`: 0..3 write X0, X1, Y0, Y1 from `ld_data[23:0]`; 4 writes A; 5 writes B; 6 writes the CCR from `ld_data[7:0]`; 7 does nothing.
- R4: On completion, N (ccr bit 3) equals bit 47 of the result accumulator.
- R5: On completion, Z (ccr bit 2) is 1 exactly when result bits 47..24 are all zero, whatever the guard and low bits hold.
- R6: On completion, V (ccr bit 1) is 0.
- R7: L (ccr bit 6) is sticky.
  - An operation sets it when `limit_event` was high in the issue cycle. A `limit_event` at any other time has no effect.
  - L is cleared by `l_clear`, or by a CCR load. A set by a completing operation wins over a clear in the same cycle.
- R8: After an issue is accepted at clock edge t:
  - `busy` is high in the two following cycles.
  - `done` is high only in the second of them.
  - The results are visible after edge t+2.
- R9: An issue, or a load, presented while `busy` is high is ignored.
- R10: CCR bits 7, 5, 4 and 0 are not changed by an operation.
- R11: Synchronous active-high `rst` clears the operand registers, the accumulators, the CCR, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe (honoured only when idle) |
| ld_sel | input | 3 | Load target code |
| ld_data | input | 56 | Load value |
| issue | input | 1 | Start an XOR operation |
| src_sel | input | 2 | Operand register select |
| dst_sel | input | 1 | Accumulator select |
| limit_event | input | 1 | Limiting occurred alongside this issue |
| l_clear | input | 1 | Clear the sticky limit flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion cycle |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| ccr | output | 8 | Condition-code register |

## Verification
The hardest cases to reach from the ports are the collisions between the unit's own timing and outside stimulus:
- an issue, a load or a limiting event arriving while the machine sits in ST_EXEC or ST_COMMIT;
- a flag clear landing in the same cycle as a commit that sets L.

The bench drives these by holding `issue` high across the busy window, pulsing a conflicting accumulator load during ST_EXEC, and timing `l_clear` onto the `done` cycle. It then checks that exactly one result lands, and that L ends up set. The flag logic is reached by preloading a slice equal to the operand with nonzero guard and low bits, which forces Z with a nonzero accumulator. A swept grid of every source and destination pair over several data sets covers the datapath itself.

// File: rtl/xor_eu_pkg.sv
package xor_eu_pkg;
    localparam int unsigned CCR_W   = 8;
    localparam int unsigned CCR_C   = 0;
    localparam int unsigned CCR_V   = 1;
    localparam int unsigned CCR_Z   = 2;
    localparam int unsigned CCR_N   = 3;
    localparam int unsigned CCR_L   = 6;
    localparam logic [2:0] LD_ACC_A = 3'd4;
    localparam logic [2:0] LD_ACC_B = 3'd5;
    localparam logic [2:0] LD_CCR   = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_COMMIT = 2'd2
    } eu_state_t;
endpackage

// File: rtl/xor_eu_fsm.sv
module xor_eu_fsm
    import xor_eu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue,
    output logic accept,
    output logic busy,
    output logic commit
);
    eu_state_t st_q, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:   if (issue) st_nx = ST_EXEC;
            ST_EXEC:   st_nx = ST_COMMIT;
            ST_COMMIT: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        busy   = 1'b0;
        commit = 1'b0;
        unique case (st_q)
            ST_IDLE:   accept = issue;
            ST_EXEC:   busy   = 1'b1;
            ST_COMMIT: begin busy = 1'b1; commit = 1'b1; end
            default:   busy   = 1'b0;
        endcase
    end
endmodule

// File: rtl/xor_eu_opregs.sv
module xor_eu_opregs #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned NREG   = 4,
    localparam int unsigned IW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] reg_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                reg_q[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                reg_q[g] <= wr_data;
        end
    end

    assign rd_data = reg_q[rd_idx];
endmodule

// File: rtl/xor_eu_slice.sv
module xor_eu_slice #(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned GUARD_W = 8,
    localparam int unsigned AW     = 2 * DATA_W + GUARD_W,
    localparam int unsigned LO     = DATA_W,
    localparam int unsigned HI     = 2 * DATA_W - 1
) (
    input  logic [AW-1:0]     acc_in,
    input  logic [DATA_W-1:0] opnd,
    output logic [AW-1:0]     acc_out,
    output logic              neg,
    output logic              zero
);
    logic [DATA_W-1:0] mid;

    always_comb begin
        mid     = acc_in[HI:LO] ^ opnd;
        acc_out = {acc_in[AW-1:HI+1], mid, acc_in[LO-1:0]};
        neg     = mid[DATA_W-1];
        zero    = (mid == '0);
    end
endmodule

// File: rtl/acc_xor_unit.sv
module acc_xor_unit
    import xor_eu_pkg::*;
#(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned GUARD_W = 8,
    localparam int unsigned AW     = 2 * DATA_W + GUARD_W,
    localparam int unsigned NREG   = 4,
    localparam int unsigned NACC   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [AW-1:0]    ld_data,
    input  logic             issue,
    input  logic [1:0]       src_sel,
    input  logic             dst_sel,
    input  logic             limit_event,
    input  logic             l_clear,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    acc_a,
    output logic [AW-1:0]    acc_b,
    output logic [CCR_W-1:0] ccr
);
    logic              accept, commit, ld_ok;
    logic [1:0]        src_q;
    logic              dst_q, lim_q;
    logic [DATA_W-1:0] opnd;
    logic [AW-1:0]     acc_q [NACC];
    logic [AW-1:0]     res;
    logic              res_neg, res_zero;
    logic [CCR_W-1:0]  ccr_q;

    assign ld_ok = ld_en && !busy;

    xor_eu_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue),
        .accept (accept),
        .busy   (busy),
        .commit (commit)
    );

    xor_eu_opregs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_ok && !ld_sel[2]),
        .wr_idx  (ld_sel[1:0]),
        .wr_data (ld_data[DATA_W-1:0]),
        .rd_idx  (src_q),
        .rd_data (opnd)
    );

    xor_eu_slice #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_slice (
        .acc_in  (acc_q[dst_q]),
        .opnd    (opnd),
        .acc_out (res),
        .neg     (res_neg),
        .zero    (res_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= 1'b0;
            lim_q <= 1'b0;
        end else if (accept) begin
            src_q <= src_sel;
            dst_q <= dst_sel;
            lim_q <= limit_event;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NACC; i++) acc_q[i] <= '0;
        end else if (commit) begin
            acc_q[dst_q] <= res;
        end else if (ld_ok && ld_sel == LD_ACC_A) begin
            acc_q[0] <= ld_data;
        end else if (ld_ok && ld_sel == LD_ACC_B) begin
            acc_q[1] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
        end else begin
            if (ld_ok && ld_sel == LD_CCR)
                ccr_q <= ld_data[CCR_W-1:0];
            else if (l_clear)
                ccr_q[CCR_L] <= 1'b0;
            if (commit) begin
                ccr_q[CCR_N] <= res_neg;
                ccr_q[CCR_Z] <= res_zero;
                ccr_q[CCR_V] <= 1'b0;
                ccr_q[CCR_L] <= (ccr_q[CCR_L] & ~l_clear) | lim_q;
            end
        end
    end

    assign done  = commit;
    assign acc_a = acc_q[0];
    assign acc_b = acc_q[1];
    assign ccr   = ccr_q;
endmodule

// File: rtl/acc_xor_unit_chk.sv
module acc_xor_unit_chk #(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned GUARD_W = 8,
    localparam int unsigned AW     = 2 * DATA_W + GUARD_W
) (
    input logic          clk,
    input logic          rst,
    input logic          issue,
    input logic          dst_sel,
    input logic          busy,
    input logic          done,
    input logic          l_clear,
    input logic          ld_en,
    input logic [2:0]    ld_sel,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b,
    input logic [7:0]    ccr
);
    logic          accepted;
    logic          dst_t;
    logic [AW-1:0] res_acc;

    assign accepted = issue && !busy;
    assign res_acc  = dst_t ? acc_b : acc_a;

    always_ff @(posedge clk) begin
        if (rst) dst_t <= 1'b0;
        else if (accepted) dst_t <= dst_sel;
    end

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (acc_a == '0 && acc_b == '0 && ccr == '0 && !busy && !done));

    assert_first_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (busy && !done));

    assert_done_second_R8: assert property (@(posedge clk) disable iff (rst)
        accepted |=> ##1 done);

    assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    assert_guard_low_kept_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(acc_a[AW-1:2*DATA_W]) && $stable(acc_a[DATA_W-1:0]) &&
                  $stable(acc_b[AW-1:2*DATA_W]) && $stable(acc_b[DATA_W-1:0])));

    assert_v_clear_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !ccr[1]);

    assert_n_flag_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> (ccr[3] == res_acc[2*DATA_W-1]));

    assert_z_flag_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> (ccr[2] == (res_acc[2*DATA_W-1:DATA_W] == '0)));

    assert_l_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ccr[6] && !l_clear && !(ld_en && !busy && ld_sel == 3'd6)) |=> ccr[6]);

    assert_other_bits_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable({ccr[7], ccr[5:4], ccr[0]}));
endmodule

bind acc_xor_unit acc_xor_unit_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (.*);

// File: tb/acc_xor_unit_tb.sv
`timescale 1ns/1ps
module acc_xor_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [55:0] ld_data = '0;
    logic        issue = 1'b0;
    logic [1:0]  src_sel = '0;
    logic        dst_sel = 1'b0;
    logic        limit_event = 1'b0;
    logic        l_clear = 1'b0;
    logic        busy, done;
    logic [55:0] acc_a, acc_b;
    logic [7:0]  ccr;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] mx [4];
    logic [55:0] ma [2];
    logic [7:0]  mccr;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    acc_xor_unit u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic load(input logic [2:0] sel, input logic [55:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        if (sel < 3'd4) mx[sel[1:0]] = d[23:0];
        else if (sel == 3'd4) ma[0] = d;
        else if (sel == 3'd5) ma[1] = d;
        else if (sel == 3'd6) mccr = d[7:0];
    endtask

    task automatic model_op(input logic [1:0] s, input logic d, input logic lim);
        logic [23:0] mid;
        mid = ma[d][47:24] ^ mx[s];
        ma[d][47:24] = mid;
        mccr[3] = mid[23];
        mccr[2] = (mid == 24'd0);
        mccr[1] = 1'b0;
        mccr[6] = mccr[6] | lim;
    endtask

    task automatic check_state(input string tag);
        chk({tag, " R1 acc_a"}, {8'd0, acc_a}, {8'd0, ma[0]});
        chk({tag, " R1 acc_b"}, {8'd0, acc_b}, {8'd0, ma[1]});
        chk({tag, " R4 R5 R6 R7 R10 ccr"}, {56'd0, ccr}, {56'd0, mccr});
    endtask

    task automatic op(input logic [1:0] s, input logic d, input logic lim, input string tag);
        issue = 1'b1; src_sel = s; dst_sel = d; limit_event = lim;
        @(negedge clk);
        issue = 1'b0; limit_event = 1'b0;
        chk({tag, " R8 busy first"}, {63'd0, busy}, 64'd1);
        chk({tag, " R8 done first"}, {63'd0, done}, 64'd0);
        @(negedge clk);
        chk({tag, " R8 done second"}, {63'd0, done}, 64'd1);
        @(negedge clk);
        model_op(s, d, lim);
        chk({tag, " R8 idle after"}, {62'd0, busy, done}, 64'd0);
        check_state(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mx[i] = '0;
        ma[0] = '0; ma[1] = '0; mccr = '0;
        // Drive junk during reset to prove it is cleared
        ld_en = 1'b1; ld_sel = 3'd4; ld_data = '1;
        repeat (3) @(negedge clk);
        ld_en = 1'b0;
        rst = 1'b0;
        chk("R11 reset busy/done", {62'd0, busy, done}, 64'd0);
        check_state("R11 reset");

        // Given case: Y1 = 3, B = 00_000005_000000
        load(3'd3, 56'h3);
        load(3'd5, 56'h00_000005_000000);
        op(2'd3, 1'b1, 1'b0, "R1 given");
        chk("R1 given B", {8'd0, acc_b}, 64'h00_000006_000000);
        chk("R4 given N", {63'd0, ccr[3]}, 64'd0);
        chk("R5 given Z", {63'd0, ccr[2]}, 64'd0);

        // Z with nonzero guard and low bits, slice cancels out
        load(3'd0, 56'h123456);
        load(3'd4, 56'hFF_123456_ABCDEF);
        op(2'd0, 1'b0, 1'b0, "R5 cancel");
        chk("R5 Z set", {63'd0, ccr[2]}, 64'd1);
        chk("R2 guard/low kept", {8'd0, acc_a}, 64'hFF_000000_ABCDEF);

        // Negative result
        load(3'd2, 56'h800000);
        op(2'd2, 1'b0, 1'b0, "R4 neg");
        chk("R4 N set", {63'd0, ccr[3]}, 64'd1);

        // Other CCR bits preserved, V cleared even if preset
        load(3'd6, 56'hB3);
        op(2'd1, 1'b1, 1'b0, "R10 keep");
        chk("R10 other bits", {56'd0, ccr & 8'hB1}, 64'hB1);
        chk("R6 V cleared", {63'd0, ccr[1]}, 64'd0);
        load(3'd6, 56'h00);

        // Sweep: every source/destination pair over several data sets
        for (int p = 0; p < 6; p++) begin
            for (int r = 0; r < 6; r++) begin
                logic [55:0] v;
                seed = nxt(seed); v[31:0] = seed;
                seed = nxt(seed); v[55:32] = seed[23:0];
                if (p == 0) v = (r < 4) ? 56'hFFFFFF : 56'hFF_FFFFFF_FFFFFF;
                load(3'(r), v);
            end
            for (int s = 0; s < 4; s++) begin
                for (int d = 0; d < 2; d++) begin
                    op(2'(s), 1'(d), 1'b0, $sformatf("R1 R3 sweep p%0d s%0d d%0d", p, s, d));
                end
            end
        end

        // Limit flag: set on issue, sticky, clear
        load(3'd6, 56'h00);
        op(2'd0, 1'b0, 1'b1, "R7 set");
        chk("R7 L set", {63'd0, ccr[6]}, 64'd1);
        op(2'd1, 1'b1, 1'b0, "R7 stay");
        chk("R7 L sticky", {63'd0, ccr[6]}, 64'd1);
        l_clear = 1'b1;
        @(negedge clk);
        l_clear = 1'b0;
        mccr[6] = 1'b0;
        chk("R7 L cleared", {63'd0, ccr[6]}, 64'd0);

        // limit_event during busy (not at issue) is ignored
        issue = 1'b1; src_sel = 2'd2; dst_sel = 1'b0; limit_event = 1'b0;
        @(negedge clk);
        issue = 1'b0; limit_event = 1'b1;
        @(negedge clk);
        limit_event = 1'b0;
        @(negedge clk);
        model_op(2'd2, 1'b0, 1'b0);
        chk("R7 late limit ignored", {63'd0, ccr[6]}, 64'd0);
        check_state("R7 late");

        // Clear arriving on the commit that sets L: set wins
        issue = 1'b1; src_sel = 2'd3; dst_sel = 1'b1; limit_event = 1'b1;
        @(negedge clk);
        issue = 1'b0; limit_event = 1'b0;
        @(negedge clk);
        l_clear = 1'b1;
        @(negedge clk);
        l_clear = 1'b0;
        model_op(2'd3, 1'b1, 1'b1);
        chk("R7 set beats clear", {63'd0, ccr[6]}, 64'd1);

        // Issue held high across busy, and a load during busy: both ignored
        issue = 1'b1; src_sel = 2'd0; dst_sel = 1'b0; limit_event = 1'b0;
        @(negedge clk);
        src_sel = 2'd1; dst_sel = 1'b1;
        ld_en = 1'b1; ld_sel = 3'd4; ld_data = 56'h11_111111_111111;
        @(negedge clk);
        ld_en = 1'b0;
        chk("R9 done once", {63'd0, done}, 64'd1);
        issue = 1'b0;
        @(negedge clk);
        model_op(2'd0, 1'b0, 1'b0);
        chk("R9 not restarted", {63'd0, busy}, 64'd0);
        check_state("R9 busy ignore");

        // Load code 7 does nothing
        load(3'd7, 56'hAA_AAAAAA_AAAAAA);
        check_state("R3 code7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule